// File: doc/BRIEF.md
# Full-Duplex Ethernet Buffer DMA Engine

This block moves frame buffers between a full-duplex Ethernet MAC and a 32-bit system memory bus. Software gives each direction a start address and a byte count and pulses a start bit. The transmit channel reads memory and passes each word, with byte strobes, to the MAC transmit FIFO. The receive channel takes words from the MAC receive FIFO and writes them to memory. Buffers may start at any byte address, have any length and cross any address boundary. The engine splits each buffer into bus bursts by itself. Unaligned head bytes go out as single transfers. Whole words go out as fixed bursts of 4, 8 or 16 beats. A remainder shorter than one fixed burst goes out as one undefined-length burst.

Only one burst is on the bus at a time. The choice between the two channels is made only while no burst is running. Receive always wins that choice. Before any bus cycle, each start is checked against the two regions that may be transferred: data RAM and external memory. A buffer that touches any other space sets a sticky error flag instead. The receive FIFO can signal that the frame has ended. Any beats that are still owed in the current burst then carry no data, and the receive channel finishes.

Top module: `eth_dma_engine`

## Requirements
- R1: When both channels are waiting at a burst boundary, the receive channel is granted. A start pulsed on both channels in the same cycle therefore produces a first bus beat with `m_write`=1, and receive finishes before any transmit beat.
- R2: `burst_sel` picks the fixed burst length: 0 gives 4 beats, 1 gives 8, and 2 or 3 give 16. A fixed burst shows `m_kind`=2'b01 with `m_blen` equal to that length.
- R3: When an aligned remainder holds fewer whole words than the fixed length, it goes out as one undefined-length burst. That burst shows `m_kind`=2'b10 and `m_blen`=0, has ceil(remaining/4) beats, and marks its final beat with `m_last`.
- R4: While the current address is not word aligned, each access is a single transfer: `m_kind`=2'b00, `m_blen`=1, `m_last`=1. Strobe bit k is set for byte lane k (address bits [1:0] = k) for each byte the buffer covers in that word.
- R5: Any start address and length are accepted in the allowed regions, including bursts that cross address boundaries. The strobes set over a whole transfer add up to exactly the byte count.
- R6: Once `rx_frame_end` is high, each remaining receive beat of the running burst has `m_strb`=0 and no `rx_pop`. After that burst the receive channel finishes with a done pulse.
- R7: A buffer is accepted only if its first and last bytes both lie in data RAM or both lie in external memory. Otherwise no bus cycle is issued and the channel's error flag is set. The flag stays set until a one is written to its clear input.
- R8: A channel's done output is a one-cycle pulse. It fires when the byte count reaches zero, and also one cycle after a start with a byte count of zero.
- R9: Once a burst has begun, its channel keeps the bus until its last beat. The address is held while `m_ready` is low.
- R10: Each transmit beat accepted on the bus appears on `tx_out_*` one cycle later, with the read word and the same strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| burst_sel | input | 2 | Fixed burst length select |
| tx_start | input | 1 | Start pulse, transmit channel |
| tx_addr | input | AW | Transmit buffer start byte address |
| tx_len | input | LW | Transmit byte count |
| tx_done | output | 1 | Transmit completion pulse |
| tx_err | output | 1 | Transmit region error, sticky |
| tx_err_clr | input | 1 | Write-one clear of tx_err |
| rx_start | input | 1 | Start pulse, receive channel |
| rx_addr | input | AW | Receive buffer start byte address |
| rx_len | input | LW | Receive byte count |
| rx_done | output | 1 | Receive completion pulse |
| rx_err | output | 1 | Receive region error, sticky |
| rx_err_clr | input | 1 | Write-one clear of rx_err |
| m_valid | output | 1 | Bus beat valid |
| m_ready | input | 1 | Bus beat accepted |
| m_write | output | 1 | 1 for write (receive), 0 for read (transmit) |
| m_addr | output | AW | Word-aligned beat address |
| m_kind | output | 2 | 00 single, 01 fixed, 10 undefined length |
| m_blen | output | 5 | Burst beats (0 for undefined length) |
| m_last | output | 1 | Final beat of the burst |
| m_strb | output | 4 | Byte lane strobes |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data |
| tx_out_valid | output | 1 | Word pushed to the MAC transmit FIFO |
| tx_out_data | output | 32 | Transmit word |
| tx_out_strb | output | 4 | Valid byte lanes of the transmit word |
| rx_in_data | input | 32 | Head word of the MAC receive FIFO |
| rx_frame_end | input | 1 | Receive FIFO holds no more frame data |
| rx_pop | output | 1 | Pop the receive FIFO head word |

## Verification
The hardest case to reach is a frame that ends partway through a fixed receive burst. That needs `rx_frame_end` to rise after a known number of real beats, while bus stalls shift those beats in time. The bench counts `rx_pop` pulses. One cycle after the sixth pop it raises the frame end, so the last two beats of the second 4-beat burst must go out as dummies. A second hard case is a tie between channels. It comes from pulsing both start inputs in one cycle and recording the order of the bus beats.

// File: rtl/eth_dma_pkg.sv
package eth_dma_pkg;

  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    XK_SINGLE = 2'b00,
    XK_FIXED  = 2'b01,
    XK_UNDEF  = 2'b10
  } xfer_kind_e;

  typedef struct packed {
    xfer_kind_e  kind;
    logic [4:0]  beats;
  } burst_plan_t;

  // Burst length from the select code.
  function automatic logic [4:0] fixed_beats(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // Byte lanes from offset 'off' that still belong to the buffer.
  function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [31:0] rem);
    logic [3:0] m;
    for (int k = 0; k < WORD_BYTES; k++)
      m[k] = (32'(k) >= 32'(off)) && (32'(k) < 32'(off) + rem);
    return m;
  endfunction

  // Shape of the next burst from the current offset and remaining bytes.
  function automatic burst_plan_t plan_burst(input logic [1:0] off, input logic [31:0] rem,
                                             input logic [4:0] fb);
    burst_plan_t p;
    if (off != 2'd0) begin
      p.kind  = XK_SINGLE;
      p.beats = 5'd1;
    end else if ((rem >> 2) >= 32'(fb)) begin
      p.kind  = XK_FIXED;
      p.beats = fb;
    end else begin
      p.kind  = XK_UNDEF;
      p.beats = 5'((rem + 32'd3) >> 2);
    end
    return p;
  endfunction

  // Both ends of [s, l] inside [base, base+size).
  function automatic logic in_window(input logic [32:0] s, input logic [32:0] l,
                                     input logic [31:0] base, input logic [31:0] size);
    return (s >= {1'b0, base}) && (l < ({1'b0, base} + {1'b0, size}));
  endfunction

endpackage

// File: rtl/eth_dma_chan.sv
module eth_dma_chan
  import eth_dma_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          LW        = 16,
  parameter logic [31:0] DRAM_BASE = 32'h2000_0000,
  parameter logic [31:0] DRAM_SIZE = 32'h0010_0000,
  parameter logic [31:0] EXT_BASE  = 32'h8000_0000,
  parameter logic [31:0] EXT_SIZE  = 32'h1000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic [LW-1:0] len_in,
  input  logic          err_clr,
  input  logic          beat_fire,
  input  logic [2:0]    beat_bytes,
  input  logic          finish,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] rem,
  output logic          done,
  output logic          err
);

  logic [32:0] first_b, last_b;
  logic        region_ok;

  assign first_b   = 33'(addr_in);
  assign last_b    = (len_in == '0) ? first_b : first_b + 33'(len_in) - 33'd1;
  assign region_ok = in_window(first_b, last_b, DRAM_BASE, DRAM_SIZE) ||
                     in_window(first_b, last_b, EXT_BASE, EXT_SIZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
      rem  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (err_clr) err <= 1'b0;
      if (start && !busy) begin
        if (!region_ok) begin
          err <= 1'b1;
        end else if (len_in == '0) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          addr <= addr_in;
          rem  <= len_in;
        end
      end else if (busy && beat_fire) begin
        addr <= addr + AW'(beat_bytes);
        rem  <= rem - LW'(beat_bytes);
        if (rem == LW'(beat_bytes)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (busy && finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/eth_dma_arb.sv
module eth_dma_arb #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] req,
  input  logic           idle,
  output logic           grant_valid,
  output logic           grant_ch
);
  // Highest index (receive) wins; decided only between bursts.
  assign grant_valid = idle && (|req);
  assign grant_ch    = req[NCH-1];
endmodule

// File: rtl/eth_dma_seq.sv
module eth_dma_seq
  import eth_dma_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    burst_sel,
  input  logic          grant_valid,
  input  logic          grant_ch,
  input  logic [1:0]    sel_off,
  input  logic [LW-1:0] sel_rem,
  input  logic          rx_frame_end,
  input  logic          m_ready,
  output logic          m_valid,
  output logic          m_write,
  output logic [1:0]    m_kind,
  output logic [4:0]    m_blen,
  output logic          m_last,
  output logic [3:0]    m_strb,
  output logic          beat_fire,
  output logic [2:0]    beat_bytes,
  output logic          fin_rx,
  output logic          in_burst,
  output logic          cur_ch,
  output logic          burst_start,
  output logic          dummy_beat
);

  xfer_kind_e  cur_kind;
  logic [4:0]  cur_blen, left;
  logic        dummy_q, fire;
  burst_plan_t plan;

  assign plan        = plan_burst(sel_off, 32'(sel_rem), fixed_beats(burst_sel));
  assign burst_start = !in_burst && grant_valid;
  assign dummy_beat  = in_burst && cur_ch && (rx_frame_end || dummy_q);
  assign m_strb      = dummy_beat ? 4'b0000 : lane_mask(sel_off, 32'(sel_rem));
  assign beat_bytes  = 3'($countones(m_strb));
  assign fire        = in_burst && m_ready;
  assign beat_fire   = fire && !dummy_beat;
  assign fin_rx      = fire && m_last && dummy_beat;

  assign m_valid = in_burst;
  assign m_write = cur_ch;
  assign m_kind  = cur_kind;
  assign m_last  = (left == 5'd1);
  assign m_blen  = (cur_kind == XK_FIXED)  ? cur_blen :
                   (cur_kind == XK_SINGLE) ? 5'd1 : 5'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst <= 1'b0;
      cur_ch   <= 1'b0;
      cur_kind <= XK_SINGLE;
      cur_blen <= '0;
      left     <= '0;
      dummy_q  <= 1'b0;
    end else if (burst_start) begin
      in_burst <= 1'b1;
      cur_ch   <= grant_ch;
      cur_kind <= plan.kind;
      cur_blen <= plan.beats;
      left     <= plan.beats;
      dummy_q  <= 1'b0;
    end else if (fire) begin
      left <= left - 5'd1;
      if (dummy_beat) dummy_q <= 1'b1;
      if (m_last) in_burst <= 1'b0;
    end
  end

endmodule

// File: rtl/eth_dma_engine.sv
module eth_dma_engine
  import eth_dma_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          LW        = 16,
  parameter logic [31:0] DRAM_BASE = 32'h2000_0000,
  parameter logic [31:0] DRAM_SIZE = 32'h0010_0000,
  parameter logic [31:0] EXT_BASE  = 32'h8000_0000,
  parameter logic [31:0] EXT_SIZE  = 32'h1000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    burst_sel,
  input  logic          tx_start,
  input  logic [AW-1:0] tx_addr,
  input  logic [LW-1:0] tx_len,
  output logic          tx_done,
  output logic          tx_err,
  input  logic          tx_err_clr,
  input  logic          rx_start,
  input  logic [AW-1:0] rx_addr,
  input  logic [LW-1:0] rx_len,
  output logic          rx_done,
  output logic          rx_err,
  input  logic          rx_err_clr,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_kind,
  output logic [4:0]    m_blen,
  output logic          m_last,
  output logic [3:0]    m_strb,
  output logic [31:0]   m_wdata,
  input  logic [31:0]   m_rdata,
  output logic          tx_out_valid,
  output logic [31:0]   tx_out_data,
  output logic [3:0]    tx_out_strb,
  input  logic [31:0]   rx_in_data,
  input  logic          rx_frame_end,
  output logic          rx_pop
);

  localparam int NCH   = 2;
  localparam int CH_RX = NCH - 1;

  logic [NCH-1:0] ch_start, ch_clr, ch_busy, ch_done, ch_err, ch_fire, ch_fin, ch_req;
  logic [AW-1:0]  ch_addr_in [NCH];
  logic [LW-1:0]  ch_len_in  [NCH];
  logic [AW-1:0]  ch_addr    [NCH];
  logic [LW-1:0]  ch_rem     [NCH];

  logic          grant_valid, grant_ch, in_burst, cur_ch, burst_start, dummy_beat;
  logic          beat_fire, fin_rx, idle_fin, sel_ch;
  logic [2:0]    beat_bytes;
  logic [AW-1:0] sel_addr;
  logic [LW-1:0] sel_rem;

  assign ch_start      = {rx_start, tx_start};
  assign ch_clr        = {rx_err_clr, tx_err_clr};
  assign ch_addr_in[0] = tx_addr;
  assign ch_addr_in[1] = rx_addr;
  assign ch_len_in[0]  = tx_len;
  assign ch_len_in[1]  = rx_len;

  // Frame already over at a boundary: receive ends without a bus cycle.
  assign idle_fin = !in_burst && ch_busy[CH_RX] && rx_frame_end;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ch_fire[c] = beat_fire && (cur_ch == c[0]);
      if (c == CH_RX) begin : g_rx
        assign ch_req[c] = ch_busy[c] && !rx_frame_end;
        assign ch_fin[c] = fin_rx || idle_fin;
      end else begin : g_tx
        assign ch_req[c] = ch_busy[c];
        assign ch_fin[c] = 1'b0;
      end
      eth_dma_chan #(
        .AW(AW), .LW(LW), .DRAM_BASE(DRAM_BASE), .DRAM_SIZE(DRAM_SIZE),
        .EXT_BASE(EXT_BASE), .EXT_SIZE(EXT_SIZE)
      ) u_chan (
        .clk(clk), .rst_n(rst_n), .start(ch_start[c]), .addr_in(ch_addr_in[c]),
        .len_in(ch_len_in[c]), .err_clr(ch_clr[c]), .beat_fire(ch_fire[c]),
        .beat_bytes(beat_bytes), .finish(ch_fin[c]), .busy(ch_busy[c]),
        .addr(ch_addr[c]), .rem(ch_rem[c]), .done(ch_done[c]), .err(ch_err[c])
      );
    end
  endgenerate

  eth_dma_arb #(.NCH(NCH)) u_arb (
    .req(ch_req), .idle(!in_burst), .grant_valid(grant_valid), .grant_ch(grant_ch)
  );

  assign sel_ch   = in_burst ? cur_ch : grant_ch;
  assign sel_addr = ch_addr[sel_ch];
  assign sel_rem  = ch_rem[sel_ch];

  eth_dma_seq #(.LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .burst_sel(burst_sel), .grant_valid(grant_valid),
    .grant_ch(grant_ch), .sel_off(sel_addr[1:0]), .sel_rem(sel_rem),
    .rx_frame_end(rx_frame_end), .m_ready(m_ready), .m_valid(m_valid),
    .m_write(m_write), .m_kind(m_kind), .m_blen(m_blen), .m_last(m_last),
    .m_strb(m_strb), .beat_fire(beat_fire), .beat_bytes(beat_bytes),
    .fin_rx(fin_rx), .in_burst(in_burst), .cur_ch(cur_ch),
    .burst_start(burst_start), .dummy_beat(dummy_beat)
  );

  assign m_addr  = {sel_addr[AW-1:2], 2'b00};
  assign m_wdata = rx_in_data;
  assign rx_pop  = m_valid && m_ready && cur_ch && !dummy_beat;
  assign tx_done = ch_done[0];
  assign rx_done = ch_done[CH_RX];
  assign tx_err  = ch_err[0];
  assign rx_err  = ch_err[CH_RX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_out_valid <= 1'b0;
      tx_out_data  <= '0;
      tx_out_strb  <= '0;
    end else begin
      tx_out_valid <= m_valid && m_ready && !cur_ch;
      tx_out_data  <= m_rdata;
      tx_out_strb  <= m_strb;
    end
  end

endmodule

// File: rtl/eth_dma_chk.sv
module eth_dma_chk
  import eth_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_valid,
  input logic          m_ready,
  input logic [AW-1:0] m_addr,
  input logic [1:0]    m_kind,
  input logic [4:0]    m_blen,
  input logic          m_last,
  input logic [3:0]    m_strb,
  input logic          rx_pop,
  input logic          tx_done,
  input logic          rx_done,
  input logic          tx_err,
  input logic          tx_err_clr,
  input logic          in_burst,
  input logic          cur_ch,
  input logic          burst_start,
  input logic          start_ch,
  input logic          rx_req,
  input logic          dummy_beat
);

  a_r1_rx_wins_tie: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start && rx_req |-> start_ch);

  a_r2_fixed_len: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && (m_kind == XK_FIXED) |-> (m_blen == 5'd4 || m_blen == 5'd8 || m_blen == 5'd16));

  a_r3_undef_no_len: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && (m_kind == XK_UNDEF) |-> (m_blen == 5'd0));

  a_r4_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && (m_kind == XK_SINGLE) |-> m_last && (m_blen == 5'd1));

  a_r6_dummy_empty: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && dummy_beat |-> (m_strb == 4'b0000) && !rx_pop);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err && !tx_err_clr |=> tx_err);

  a_r8_tx_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  a_r8_rx_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_kind));

  a_r9_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && !(m_ready && m_last) |=> in_burst && $stable(cur_ch));

endmodule

bind eth_dma_engine eth_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
  .m_kind(m_kind), .m_blen(m_blen), .m_last(m_last), .m_strb(m_strb), .rx_pop(rx_pop),
  .tx_done(tx_done), .rx_done(rx_done), .tx_err(tx_err), .tx_err_clr(tx_err_clr),
  .in_burst(in_burst), .cur_ch(cur_ch), .burst_start(burst_start), .start_ch(grant_ch),
  .rx_req(ch_req[1]), .dummy_beat(dummy_beat)
);

// File: tb/sim_eth_dma_engine.sv
module sim_eth_dma_engine;

  typedef struct packed {
    logic        ch;     // 0 transmit, 1 receive
    logic [31:0] addr;
    logic [15:0] len;
    logic [1:0]  bsel;
    logic [7:0]  beats;
    logic [15:0] bytes;
    logic [3:0]  sgl;
    logic [3:0]  fix;
    logic [3:0]  und;
    logic        err;
    logic [3:0]  dones;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h2000_0000, 16'd64, 2'd0,  8'd16, 16'd64, 4'd0, 4'd4, 4'd0, 1'b0, 4'd1},
    '{1'b0, 32'h2000_0001, 16'd40, 2'd1,  8'd11, 16'd40, 4'd1, 4'd1, 4'd1, 1'b0, 4'd1},
    '{1'b1, 32'h8000_0002, 16'd2,  2'd2,  8'd1,  16'd2,  4'd1, 4'd0, 4'd0, 1'b0, 4'd1},
    '{1'b1, 32'h8000_0000, 16'd70, 2'd2,  8'd18, 16'd70, 4'd0, 4'd1, 4'd1, 1'b0, 4'd1},
    '{1'b0, 32'h2000_0003, 16'd9,  2'd0,  8'd3,  16'd9,  4'd1, 4'd0, 4'd1, 1'b0, 4'd1},
    '{1'b0, 32'h1000_0000, 16'd16, 2'd0,  8'd0,  16'd0,  4'd0, 4'd0, 4'd0, 1'b1, 4'd0},
    '{1'b1, 32'h200F_FFF0, 16'd32, 2'd0,  8'd0,  16'd0,  4'd0, 4'd0, 4'd0, 1'b1, 4'd0},
    '{1'b0, 32'h2000_0100, 16'd0,  2'd0,  8'd0,  16'd0,  4'd0, 4'd0, 4'd0, 1'b0, 4'd1},
    '{1'b0, 32'h2000_03F8, 16'd32, 2'd1,  8'd8,  16'd32, 4'd0, 4'd1, 4'd0, 1'b0, 4'd1},
    '{1'b1, 32'h8000_0101, 16'd14, 2'd0,  8'd4,  16'd14, 4'd1, 4'd0, 4'd1, 1'b0, 4'd1}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  burst_sel = '0;
  logic        tx_start = 0, rx_start = 0, tx_err_clr = 0, rx_err_clr = 0;
  logic [31:0] tx_addr = '0, rx_addr = '0;
  logic [15:0] tx_len = '0, rx_len = '0;
  logic        tx_done, tx_err, rx_done, rx_err;
  logic        m_valid, m_ready = 1'b1, m_write, m_last;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_kind;
  logic [4:0]  m_blen;
  logic [3:0]  m_strb;
  logic        tx_out_valid, rx_pop, rx_frame_end = 1'b0;
  logic [31:0] tx_out_data, rx_in_data;
  logic [3:0]  tx_out_strb;

  int cyc = 0, n_chk = 0, n_bad = 0;
  int beats, bytes, sgl, fix, und, dones, pops, data_bad, first_blen;
  int first_write, last_rx_idx, first_tx_idx;
  logic first_beat, pend_v;
  logic [31:0] pend_d;
  logic [3:0]  pend_s;

  assign m_rdata    = m_addr ^ 32'h5A5A_0000;
  assign rx_in_data = {16'hC0DE, 16'(pops)};

  eth_dma_engine u0 (.*);

  always #5 clk = ~clk;

  // Bus stalls on one cycle in five; settled well before the next edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 m_ready = ((cyc % 5) != 3);
  end

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d cycles expected<150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic clear_counts();
    beats = 0; bytes = 0; sgl = 0; fix = 0; und = 0; dones = 0; pops = 0;
    data_bad = 0; first_beat = 1'b1; first_write = -1; first_blen = -1;
    last_rx_idx = -1; first_tx_idx = -1;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (tx_out_valid) begin
      if (!pend_v || tx_out_data !== pend_d || tx_out_strb !== pend_s) data_bad++;
      pend_v = 1'b0;
    end
    if (tx_done) dones++;
    if (rx_done) dones++;
    if (rx_pop) pops++;
    if (m_valid && m_ready) begin
      if (first_write < 0) first_write = int'(m_write);
      if (first_beat) begin
        if (first_blen < 0) first_blen = int'(m_blen);
        case (m_kind)
          2'b00: sgl++;
          2'b01: fix++;
          2'b10: und++;
          default: ;
        endcase
      end
      if (m_write) last_rx_idx = beats;
      else if (first_tx_idx < 0) first_tx_idx = beats;
      beats++;
      bytes += $countones(m_strb);
      first_beat = m_last;
      if (!m_write) begin
        pend_v = 1'b1; pend_d = m_addr ^ 32'h5A5A_0000; pend_s = m_strb;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_quiet(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((dones > 0 || tx_err || rx_err) && !m_valid) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_errs();
    @(negedge clk) begin tx_err_clr = 1; rx_err_clr = 1; end
    @(negedge clk) begin tx_err_clr = 0; rx_err_clr = 0; end
  endtask

  initial begin
    clear_counts();
    pend_v = 1'b0;
    repeat (3) @(negedge clk);
    // Reset state (R8, R7)
    chk("R8", "reset m_valid", int'(m_valid), 0);
    chk("R8", "reset done", int'(tx_done | rx_done), 0);
    chk("R7", "reset err", int'(tx_err | rx_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R2 R3 R4 R5 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      clear_counts();
      burst_sel = VECS[v].bsel;
      if (VECS[v].ch) begin rx_addr = VECS[v].addr; rx_len = VECS[v].len; rx_start = 1; end
      else            begin tx_addr = VECS[v].addr; tx_len = VECS[v].len; tx_start = 1; end
      @(negedge clk) begin tx_start = 0; rx_start = 0; end
      wait_quiet(500);
      chk("R5", $sformatf("v%0d beats", v), beats, int'(VECS[v].beats));
      chk("R5", $sformatf("v%0d bytes", v), bytes, int'(VECS[v].bytes));
      chk("R4", $sformatf("v%0d singles", v), sgl, int'(VECS[v].sgl));
      chk("R2", $sformatf("v%0d fixed bursts", v), fix, int'(VECS[v].fix));
      chk("R3", $sformatf("v%0d undef bursts", v), und, int'(VECS[v].und));
      chk("R7", $sformatf("v%0d err", v), int'(VECS[v].ch ? rx_err : tx_err), int'(VECS[v].err));
      chk("R8", $sformatf("v%0d done pulses", v), dones, int'(VECS[v].dones));
      chk("R10", $sformatf("v%0d tx word mismatches", v), data_bad, 0);
      clear_errs();
    end

    // R1 / R9: both channels started in the same cycle
    clear_counts();
    burst_sel = 2'd0;
    tx_addr = 32'h2000_0200; tx_len = 16'd32;
    rx_addr = 32'h8000_0200; rx_len = 16'd32;
    tx_start = 1; rx_start = 1;
    @(negedge clk) begin tx_start = 0; rx_start = 0; end
    for (int i = 0; i < 300 && dones < 2; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R1", "first beat is receive write", first_write, 1);
    chk("R9", "tx starts after last rx beat", int'(first_tx_idx > last_rx_idx), 1);
    chk("R1", "tie total beats", beats, 16);
    chk("R8", "tie done pulses", dones, 2);

    // R6: frame ends after six real receive beats of 4-beat bursts
    clear_counts();
    rx_addr = 32'h8000_0400; rx_len = 16'd64;
    rx_start = 1;
    @(negedge clk) rx_start = 0;
    wait (pops == 6);
    @(posedge clk);
    #1 rx_frame_end = 1'b1;
    wait_quiet(200);
    chk("R6", "dummy run beats", beats, 8);
    chk("R6", "dummy run bytes", bytes, 24);
    chk("R6", "dummy run pops", pops, 6);
    chk("R6", "dummy run done", dones, 1);
    rx_frame_end = 1'b0;
    repeat (2) @(negedge clk);

    // R7: forbidden region, sticky flag, write-one clear
    clear_counts();
    tx_addr = 32'h0000_1000; tx_len = 16'd8;
    tx_start = 1;
    @(negedge clk) tx_start = 0;
    repeat (8) @(negedge clk);
    chk("R7", "forbidden beats", beats, 0);
    chk("R7", "err sticky", int'(tx_err), 1);
    @(negedge clk) tx_err_clr = 1;
    @(negedge clk) tx_err_clr = 0;
    chk("R7", "err after clear", int'(tx_err), 0);

    // R2: select code 3 gives 16-beat bursts
    clear_counts();
    burst_sel = 2'd3;
    tx_addr = 32'h2000_0800; tx_len = 16'd64;
    tx_start = 1;
    @(negedge clk) tx_start = 0;
    wait_quiet(300);
    chk("R2", "sel3 burst length", first_blen, 16);
    chk("R2", "sel3 fixed bursts", fix, 1);
    chk("R10", "sel3 tx word mismatches", data_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule